// File: doc/BRIEF.md
# Four-Channel Match Timer with Watchdog

This block is a memory-mapped system timer. A single 32-bit up-counter advances on each clock cycle where the tick enable input is high. Four 32-bit compare registers are checked against that counter. When the counter reaches a compare value and the matching channel is enabled, a sticky status bit is set and the channel's interrupt line rises. Software acknowledges an event by writing a one to its status bit.

Channel 3 can also act as a watchdog. If bit 0 of the watchdog-arm register is set when channel 3 matches, the block emits a one-cycle reset request and disarms itself by clearing that register. This happens whether or not channel 3's interrupt is enabled. Software reaches every register through a simple synchronous bus: write strobe, read strobe, byte address and 32-bit data. Reads are combinational and complete in the same cycle.

Top module: `os_match_timer`

## Requirements
- R1: After reset the counter, all four compare registers, status, interrupt enable and watchdog-arm register read zero, all interrupt lines are low and the reset request is low.
- R2: The counter increases by one on each clock where `tick_en` is high, wraps from 0xFFFFFFFF to 0, and holds its value while `tick_en` is low.
- R3: A write to the counter (address 0x10) loads the written value and takes priority over a tick in the same cycle; counting then continues from that value.
- R4: A channel N event occurs in the cycle after the counter newly becomes equal to compare register N, whether the counter moved there or the compare register was written to the current count. A counter that stays on that value raises no further event. If interrupt-enable bit N is set, the event sets status bit N (address 0x14) and raises `irq[N]`. Compare registers 0 to 3 sit at 0x00, 0x04, 0x08 and 0x0C.
- R5: An event on a channel whose enable bit is clear leaves its status bit and interrupt line unchanged, and enabling the channel later does not set them for that past event.
- R6: A write to status clears exactly the bits written as 1 and leaves the others set; `irq[N]` always equals status bit N. A new event in the same cycle as a clear wins, so the bit stays set.
- R7: The interrupt-enable register (address 0x1C) stores only bits 11:0 of a write; bits 31:12 read as zero.
- R8: A channel-3 event while bit 0 of the watchdog-arm register (address 0x18) is set raises `rst_req` for exactly one cycle, the cycle after the counter reaches the value. In that same cycle the watchdog-arm register reads zero, regardless of interrupt enable bit 3, and the clear wins over a write to that register in the same cycle.
- R9: The watchdog-arm register stores all 32 written bits. A channel-3 event while its bit 0 is clear produces no reset request and leaves the register unchanged.
- R10: A read of any address other than 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18 and 0x1C returns zero, and `bus_rdata` is zero whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter advance enable |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW (8) | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| irq | output | 4 | Per-channel interrupt lines |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench targets these cases:
- A counter parked on a compare value. A design that compared levels instead of arrivals would set the status bit again after every acknowledge.
- A counter wrapping through zero into a zero compare value while the channel is disabled. A design that latched unconditionally would show a late interrupt once the channel is enabled.
- Acknowledge writes that name bits which are not set, or that land in the same cycle as a fresh event. A design that cleared or lost the wrong bit would drop an interrupt.
- A watchdog match with interrupt bit 3 off. Missing the reset there, stretching the pulse, or failing to disarm would give wrong reset pulse counts or a non-zero read-back.

// File: rtl/os_match_timer.sv
module os_match_timer #(
  parameter int AW      = 8,
  parameter int IE_BITS = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic [3:0]    irq,
  output logic          rst_req
);
  localparam int NCH = 4;
  localparam int WCH = NCH - 1;
  localparam logic [AW-1:0] A_CNT = AW'(8'h10);
  localparam logic [AW-1:0] A_ST  = AW'(8'h14);
  localparam logic [AW-1:0] A_WD  = AW'(8'h18);
  localparam logic [AW-1:0] A_IE  = AW'(8'h1C);

  logic [31:0]        cnt, wden, rd_mux;
  logic [31:0]        cmp [NCH];
  logic [NCH-1:0]     st, eq_q, eq_d, fire;
  logic [IE_BITS-1:0] ie;
  logic               rst_q;

  wire wr_cnt = bus_wr && bus_addr == A_CNT;
  wire wr_st  = bus_wr && bus_addr == A_ST;
  wire wr_wd  = bus_wr && bus_addr == A_WD;
  wire wr_ie  = bus_wr && bus_addr == A_IE;
  wire wd_hit = fire[WCH] && wden[0];

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (wr_cnt) cnt <= bus_wdata;
    else if (tick_en) cnt <= cnt + 32'd1;
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) cmp[n] <= '0;
      else if (bus_wr && bus_addr == AW'(n * 4)) cmp[n] <= bus_wdata;
    end
    assign eq_d[n] = (cnt == cmp[n]);
  end

  assign fire = eq_d & ~eq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eq_q  <= '1;
      st    <= '0;
      ie    <= '0;
      wden  <= '0;
      rst_q <= 1'b0;
    end else begin
      eq_q  <= eq_d;
      st    <= (st & ~(wr_st ? bus_wdata[NCH-1:0] : '0)) | (fire & ie[NCH-1:0]);
      rst_q <= wd_hit;
      if (wr_ie) ie <= bus_wdata[IE_BITS-1:0];
      if (wd_hit)     wden <= '0;
      else if (wr_wd) wden <= bus_wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int n = 0; n < NCH; n++)
      if (bus_addr == AW'(n * 4)) rd_mux = cmp[n];
    case (bus_addr)
      A_CNT:   rd_mux = cnt;
      A_ST:    rd_mux = 32'(st);
      A_WD:    rd_mux = wden;
      A_IE:    rd_mux = 32'(ie);
      default: ;
    endcase
  end

  assign bus_rdata = bus_rd ? rd_mux : '0;
  assign irq       = st;
  assign rst_req   = rst_q;

  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !wr_cnt) |=> cnt == $past(cnt) + 32'd1);
  p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !wr_cnt) |=> $stable(cnt));
  p_cnt_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> cnt == $past(bus_wdata));
  p_new_bit_needs_ie_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st & ~$past(st)) & ~$past(ie[NCH-1:0])) == '0);
  p_no_silent_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_st |=> (st & $past(st)) == $past(st));
  p_pulse_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  p_pulse_disarms_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> wden == '0);
  p_pulse_needs_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(wden[0]));
endmodule

// File: tb/sim_os_match_timer.sv
module sim_os_match_timer;
  logic        clk = 0, rst_n = 0, tick_en = 0, bus_wr = 0, bus_rd = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq;
  logic        rst_req;

  always #2.5 clk = ~clk;

  os_match_timer u0 (.clk, .rst_n, .tick_en, .bus_wr, .bus_rd, .bus_addr,
                     .bus_wdata, .bus_rdata, .irq, .rst_req);

  int errors = 0, checks = 0, rst_seen = 0, cycles = 0;
  logic [31:0] last_rd;
  bit done = 0;

  // behavioural reference
  logic [31:0] m_cnt, m_wd, m_ie;
  logic [31:0] m_cmp [4];
  bit   [3:0]  m_st, m_was_eq, m_ev;
  bit          m_rst;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_cnt = 0; m_wd = 0; m_ie = 0; m_st = 0; m_rst = 0; m_was_eq = 4'hF;
      foreach (m_cmp[i]) m_cmp[i] = 0;
    end else begin
      for (int i = 0; i < 4; i++) begin
        m_ev[i]     = (m_cnt == m_cmp[i]) && !m_was_eq[i];
        m_was_eq[i] = (m_cnt == m_cmp[i]);
      end
      if (bus_wr && bus_addr == 8'h14) m_st = m_st & ~bus_wdata[3:0];
      m_st  = m_st | (m_ev & m_ie[3:0]);
      m_rst = m_ev[3] && m_wd[0];
      if (m_rst) m_wd = 0;
      else if (bus_wr && bus_addr == 8'h18) m_wd = bus_wdata;
      if (bus_wr && bus_addr == 8'h1C) m_ie = bus_wdata & 32'hFFF;
      if (bus_wr && bus_addr == 8'h10) m_cnt = bus_wdata;
      else if (tick_en) m_cnt = m_cnt + 1;
      if (bus_wr && bus_addr < 8'h10 && bus_addr[1:0] == 0) m_cmp[bus_addr[3:2]] = bus_wdata;
    end
  end

  function automatic logic [31:0] m_read(logic [7:0] a);
    case (a)
      8'h00, 8'h04, 8'h08, 8'h0C: return m_cmp[a[3:2]];
      8'h10: return m_cnt;
      8'h14: return {28'd0, m_st};
      8'h18: return m_wd;
      8'h1C: return m_ie;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(bit wr, bit rd, logic [7:0] a, logic [31:0] d, bit tk);
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; tick_en = tk;
    #1;
    last_rd = bus_rdata;
    if (rst_req) rst_seen++;
    if (rst_n) begin
      chk("R6 irq", {28'd0, irq}, {28'd0, m_st});
      chk("R8 rst_req", {31'd0, rst_req}, {31'd0, m_rst});
      chk("R10 rdata", bus_rdata, rd ? m_read(a) : 32'd0);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d); cyc(1, 0, a, d, 0); endtask
  task automatic idle(int n, bit tk); for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, tk); endtask
  task automatic rd(logic [7:0] a); cyc(0, 1, a, 0, 0); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(1, 0);
    // R1
    for (int a = 0; a < 8'h20; a += 4) begin rd(8'(a)); chk("R1 reg", last_rd, 0); end
    chk("R1 irq", {28'd0, irq}, 0);
    chk("R1 rst_req", {31'd0, rst_req}, 0);
    // R7
    wr(8'h1C, 32'hFFFF_FFFF); rd(8'h1C); chk("R7 ie width", last_rd, 32'h0000_0FFF);
    wr(8'h1C, 0);
    // R3, R2
    cyc(1, 0, 8'h10, 32'hFFFF_FFFD, 1); rd(8'h10); chk("R3 load", last_rd, 32'hFFFF_FFFD);
    idle(3, 1); rd(8'h10); chk("R2 wrap", last_rd, 32'h0);
    idle(4, 0); rd(8'h10); chk("R2 hold", last_rd, 32'h0);
    // R5: channel 0 matched at zero while disabled
    wr(8'h1C, 32'h1); idle(2, 0); rd(8'h14); chk("R5 no late set", last_rd, 0);
    chk("R5 irq", {28'd0, irq}, 0);
    // R4
    wr(8'h1C, 32'h2); wr(8'h04, 32'h20); wr(8'h10, 32'h1C);
    idle(4, 1); idle(2, 0);
    rd(8'h14); chk("R4 status", last_rd, 32'h2); chk("R4 irq", {28'd0, irq}, 4'h2);
    wr(8'h14, 32'h2); idle(5, 0);
    rd(8'h14); chk("R4 once per arrival", last_rd, 0);
    // R6
    wr(8'h00, 32'h30); wr(8'h08, 32'h30); wr(8'h1C, 32'h5); wr(8'h10, 32'h2F);
    idle(1, 1); idle(2, 0);
    rd(8'h14); chk("R6 both set", last_rd, 32'h5);
    wr(8'h14, 32'hA); rd(8'h14); chk("R6 unset bits ignored", last_rd, 32'h5);
    wr(8'h14, 32'h1); rd(8'h14); chk("R6 clear one", last_rd, 32'h4);
    chk("R6 irq follows", {28'd0, irq}, 4'h4);
    wr(8'h14, 32'hF);
    // R8
    wr(8'h1C, 0); wr(8'h0C, 32'h40); wr(8'h18, 32'h1); wr(8'h10, 32'h3E);
    rst_seen = 0;
    idle(2, 1); idle(3, 0);
    chk("R8 one pulse", rst_seen, 1);
    rd(8'h18); chk("R8 disarmed", last_rd, 0);
    rd(8'h14); chk("R8 no status", last_rd, 0);
    // R9
    wr(8'h18, 32'hFFFF_FFFE); rd(8'h18); chk("R9 full width", last_rd, 32'hFFFF_FFFE);
    rst_seen = 0; wr(8'h10, 32'h3F); idle(1, 1); idle(3, 0);
    chk("R9 no pulse", rst_seen, 0);
    rd(8'h18); chk("R9 kept", last_rd, 32'hFFFF_FFFE);
    // R10
    rd(8'h24); chk("R10 unmapped", last_rd, 0);
    rd(8'h0D); chk("R10 unaligned", last_rd, 0);
    rd(8'h0C); chk("R10 map", last_rd, 32'h40);
    // mixed traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int op = $urandom % 10;
      logic [7:0] a = 8'(($urandom % 9) * 4);
      logic [31:0] d = (a == 8'h14 || a == 8'h1C || a == 8'h18) ? $urandom : ($urandom % 48);
      if (op < 3) cyc(1, 0, a, d, ($urandom % 4) != 0);
      else if (op < 6) cyc(0, 1, a, 0, ($urandom % 4) != 0);
      else cyc(0, 0, 0, 0, ($urandom % 4) != 0);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(negedge clk) if (!done && cycles > 200000) begin
    errors++; checks++;
    done = 1;
    $display("FAIL watchdog actual=%0d expected<200000", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule